// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine on the slave side of an I2C-compatible two-wire link. It sits in front of a byte-addressed memory of up to 1 KB, split into 256-byte blocks. It does not see the raw pads. Instead it takes SCL and SDA values that are already synchronised to its clock, together with one-cycle START and STOP strobes from an outside line monitor. It answers only through an open-drain pull-down enable for SDA.

The engine decodes the control byte and keeps a word-address pointer. The block-select field of the control byte forms the upper pointer bits. Received write data goes out to a page-buffer interface as one-cycle strobes. Reads take data from a synchronous RAM whose read address is always the pointer, and the engine supports current-address, random and sequential reads.

While an outside write-commit cycle is in progress (busy input high), the engine withholds every acknowledge. A bus master can therefore poll for completion by sending a write control byte and watching for the ACK.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset, `sda_oe` and `pb_we` are 0 and `mem_raddr` is 0.
- R2: Bits 7:4 of the first byte after a START must be 1010. Any other value gets no ACK, and the rest of that transaction gets no ACK, no drive and no page-buffer strobe.
- R3: The slave acknowledges a byte by setting `sda_oe` to 1 (SDA pulled low). `sda_oe` rises after the SCL fall that follows the eighth data bit, stays high through the ninth SCL high phase, and drops after the next SCL fall.
- R4: While `busy_i` is 1, no byte gets an ACK, the control byte included. The whole transaction is then ignored. Once `busy_i` is 0, a write control byte is acknowledged again, which lets the master poll for completion.
- R5: Control-byte bits 3:1 are block select. The low ADDR_W-8 of them (bits 2:1 at the default ADDR_W=10) load the upper pointer bits. Bit 3 is ignored.
- R6: Control bit 0 chooses the direction: 1 is read, 0 is write. After a write control byte, the next byte loads pointer bits 7:0. Each later byte is acknowledged and produces one `pb_we` pulse, with `pb_addr` equal to the pointer and `pb_wdata` equal to the byte.
- R7: After each write data byte, only the low log2(PAGE_BYTES) pointer bits increment, modulo the page size (16 at the default). The upper bits stay unchanged.
- R8: Read data leaves MSB first. `sda_oe` = 1 means a 0 bit. The engine changes `sda_oe` only while SCL is low, and it leaves SDA released during the master's ACK slot.
- R9: A current-address read (read control byte right after START) returns the byte at the address after the last byte read or written, provided the block bits match.
- R10: A random read is a write control byte plus a word address, then a repeated START and a read control byte. It returns the byte at that address, because the pointer stays loaded even though no data byte was written.
- R11: During a read, an ACK from the master fetches the next byte. The pointer increments by one after every byte sent and wraps from the last location to 0. A NACK releases SDA, and every bit that follows is ignored until the next START.
- R12: A STOP or START strobe at any point aborts the byte in progress. No page-buffer strobe is issued for a partial byte. After a STOP, bits are ignored until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_s | input | 1 | Synchronised SCL level |
| sda_s | input | 1 | Synchronised SDA level (resolved bus) |
| start_stb | input | 1 | One-cycle START (or repeated START) indication |
| stop_stb | input | 1 | One-cycle STOP indication |
| busy_i | input | 1 | Internal write-commit cycle in progress |
| mem_rdata | input | 8 | Synchronous RAM read data, one cycle after `mem_raddr` |
| sda_oe | output | 1 | Pull SDA low when 1 |
| mem_raddr | output | ADDR_W | Current word-address pointer, used as RAM read address |
| pb_we | output | 1 | One-cycle page-buffer write strobe |
| pb_addr | output | ADDR_W | Page-buffer target address |
| pb_wdata | output | 8 | Page-buffer write data |

## Verification
Every SCL edge is detected in the clock cycle in which the new `scl_s` level is first sampled. The resulting `sda_oe` change is registered there, so it appears one clock after the SCL change. `pb_we` appears one clock after the SCL fall that opens the ACK slot. Read data is fetched from the pointer one cycle after the pointer moves, which is many cycles before it is needed. The bench holds each SCL phase for four clocks and samples at the end of a phase, well after every one of these results. The ACK value is read at the end of the ninth high phase, and the release is checked at the end of the following low phase.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_READ
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam logic [3:0] BIT_ACK  = 4'd8;
  localparam logic [3:0] BIT_END  = 4'd9;
endpackage

// File: rtl/eep_scl_edge.sv
module eep_scl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/eep_bit_ctr.sv
module eep_bit_ctr
  import eep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       sda_i,
  output logic [3:0] cnt_o,
  output logic [7:0] rx_o
);
  logic [3:0] cnt_n;
  logic [7:0] rx_n;

  always_comb begin
    cnt_n = cnt_o;
    rx_n  = rx_o;
    if (clr_i) begin
      cnt_n = '0;
    end else if (rise_i && cnt_o < BIT_ACK) begin
      rx_n  = {rx_o[6:0], sda_i};
      cnt_n = cnt_o + 4'd1;
    end else if (rise_i && cnt_o == BIT_ACK) begin
      cnt_n = BIT_END;
    end else if (fall_i && cnt_o == BIT_END) begin
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      rx_o  <= '0;
    end else begin
      cnt_o <= cnt_n;
      rx_o  <= rx_n;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= BIT_END);
endmodule

// File: rtl/eep_ptr.sv
module eep_ptr #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_hi_i,
  input  logic [ADDR_W-9:0]   hi_i,
  input  logic                load_lo_i,
  input  logic [7:0]          lo_i,
  input  logic                inc_page_i,
  input  logic                inc_all_i,
  output logic [ADDR_W-1:0]   ptr_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr_o;
    if (load_hi_i) ptr_n[ADDR_W-1:8] = hi_i;
    if (load_lo_i) ptr_n[7:0] = lo_i;
    if (inc_page_i) ptr_n[PAGE_W-1:0] = ptr_o[PAGE_W-1:0] + 1'b1;
    if (inc_all_i)  ptr_n = ptr_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_o <= '0;
    else        ptr_o <= ptr_n;
  end

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_page_i |=> ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W]));

  // R11
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_all_i && (&ptr_o)) |=> ptr_o == '0);
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              start_stb,
  input  logic              stop_stb,
  input  logic              busy_i,
  input  logic [7:0]        mem_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              pb_we,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [7:0]        pb_wdata
);
  localparam int BLK_W = ADDR_W - 8;

  logic [1:0] rst_sync;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ln = rst_sync[1];

  logic       scl_rise, scl_fall;
  logic [3:0] cnt;
  logic [7:0] rx;
  logic       ctr_clr;
  logic       ld_hi, ld_lo, inc_page, inc_all;
  logic [ADDR_W-1:0] ptr;

  eep_scl_edge u_edge (
    .clk(clk), .rst_n(rst_ln), .scl_i(scl_s),
    .rise_o(scl_rise), .fall_o(scl_fall)
  );

  eep_bit_ctr u_ctr (
    .clk(clk), .rst_n(rst_ln), .clr_i(ctr_clr),
    .rise_i(scl_rise), .fall_i(scl_fall), .sda_i(sda_s),
    .cnt_o(cnt), .rx_o(rx)
  );

  eep_ptr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_ln),
    .load_hi_i(ld_hi), .hi_i(rx[BLK_W:1]),
    .load_lo_i(ld_lo), .lo_i(rx),
    .inc_page_i(inc_page), .inc_all_i(inc_all),
    .ptr_o(ptr)
  );

  eep_state_e state_q, state_n;
  logic       oe_n;
  logic [7:0] tx_q, tx_n;
  logic       pb_we_n;

  always_comb begin
    state_n  = state_q;
    oe_n     = sda_oe;
    tx_n     = tx_q;
    pb_we_n  = 1'b0;
    ld_hi    = 1'b0;
    ld_lo    = 1'b0;
    inc_page = 1'b0;
    inc_all  = 1'b0;
    ctr_clr  = 1'b0;
    if (start_stb) begin
      state_n = ST_CTRL;
      oe_n    = 1'b0;
      ctr_clr = 1'b1;
    end else if (stop_stb) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      ctr_clr = 1'b1;
    end else begin
      case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_fall && cnt == BIT_ACK) begin
            if (busy_i) begin
              state_n = ST_IDLE;
            end else if (state_q == ST_CTRL) begin
              if (rx[7:4] == DEV_CODE) begin
                oe_n    = 1'b1;
                ld_hi   = 1'b1;
                state_n = rx[0] ? ST_READ : ST_ADDR;
              end else begin
                state_n = ST_IDLE;
              end
            end else if (state_q == ST_ADDR) begin
              oe_n    = 1'b1;
              ld_lo   = 1'b1;
              state_n = ST_WDATA;
            end else begin
              oe_n     = 1'b1;
              pb_we_n  = 1'b1;
              inc_page = 1'b1;
            end
          end else if (scl_fall && cnt == BIT_END) begin
            oe_n = 1'b0;
          end
        end
        ST_READ: begin
          if (scl_fall && cnt == BIT_END) begin
            tx_n = mem_rdata;
            oe_n = ~mem_rdata[7];
          end else if (scl_fall && cnt != 4'd0 && cnt < BIT_ACK) begin
            tx_n = {tx_q[6:0], 1'b0};
            oe_n = ~tx_q[6];
          end else if (scl_fall && cnt == BIT_ACK) begin
            oe_n    = 1'b0;
            inc_all = 1'b1;
          end else if (scl_rise && cnt == BIT_ACK && sda_s) begin
            state_n = ST_IDLE;
            ctr_clr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      state_q  <= ST_IDLE;
      sda_oe   <= 1'b0;
      tx_q     <= '0;
      pb_we    <= 1'b0;
      pb_addr  <= '0;
      pb_wdata <= '0;
    end else begin
      state_q <= state_n;
      sda_oe  <= oe_n;
      tx_q    <= tx_n;
      pb_we   <= pb_we_n;
      if (pb_we_n) begin
        pb_addr  <= ptr;
        pb_wdata <= rx;
      end
    end
  end

  assign mem_raddr = ptr;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q == ST_IDLE && !start_stb) |=> !sda_oe);

  // R4
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (sda_oe && !$past(sda_oe) && $past(state_q) != ST_READ) |-> !$past(busy_i));

  // R8
  scl_low_drive_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    ((sda_oe != $past(sda_oe)) && !$past(start_stb) && !$past(stop_stb))
      |-> !$past(scl_s));

  // R6
  pb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    pb_we |-> ($past(state_q) == ST_WDATA) && !$past(pb_we));
endmodule

// File: tb/sim_eeprom_2w_slave.sv
module sim_eeprom_2w_slave;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl = 1'b1;
  logic          sda_m = 1'b1;
  logic          start_stb = 1'b0;
  logic          stop_stb = 1'b0;
  logic          busy = 1'b0;
  logic [7:0]    mem_rdata;
  logic          sda_oe;
  logic [AW-1:0] mem_raddr;
  logic          pb_we;
  logic [AW-1:0] pb_addr;
  logic [7:0]    pb_wdata;
  logic          sda_line;

  logic [7:0] ram     [1024];
  logic [7:0] exp_mem [1024];
  int         pb_cnt = 0;
  logic [AW-1:0] pb_a;
  logic [7:0] pb_d;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  eeprom_2w_slave #(.ADDR_W(AW), .PAGE_BYTES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_s(scl), .sda_s(sda_line),
    .start_stb(start_stb), .stop_stb(stop_stb), .busy_i(busy),
    .mem_rdata(mem_rdata), .sda_oe(sda_oe), .mem_raddr(mem_raddr),
    .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata)
  );

  always @(posedge clk) begin
    if (pb_we) begin
      ram[pb_addr] <= pb_wdata;
      pb_cnt <= pb_cnt + 1;
      pb_a   <= pb_addr;
      pb_d   <= pb_wdata;
    end
    mem_rdata <= ram[mem_raddr];
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half();
    sda_m = 1'b0; start_stb = 1'b1; @(negedge clk); start_stb = 1'b0;
    half(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half();
    sda_m = 1'b1; stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0;
    half();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack, output bit rel);
    send_bits(b, 8);
    sda_m = 1'b1; half(); scl = 1'b1; half();
    ack = sda_oe;
    scl = 1'b0; half();
    rel = !sda_oe;
  endtask

  task automatic rd_byte(input bit m_ack, output logic [7:0] b, output bit stable);
    logic s0;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1'b1; s0 = sda_oe; half();
      b[i] = sda_line;
      if (sda_oe != s0) stable = 1'b0;
      scl = 1'b0;
    end
    sda_m = m_ack ? 1'b0 : 1'b1;
    half(); scl = 1'b1;
    if (sda_oe) stable = 1'b0;
    half(); scl = 1'b0; sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
    chk(pb_we == 1'b0, "R1 pb_we", int'(pb_we), 0);
    chk(mem_raddr == '0, "R1 ptr", int'(mem_raddr), 0);
  endtask

  task automatic t_bad_code();
    bit a, r; int c0;
    c0 = pb_cnt;
    bus_start();
    wr_byte(8'h30, a, r); chk(!a, "R2 bad code ack", a, 0);
    wr_byte(8'h55, a, r); chk(!a, "R2 ignored byte ack", a, 0);
    chk(pb_cnt == c0, "R2 no strobe", pb_cnt, c0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    bit a, r;
    bus_start();
    wr_byte(8'hA4, a, r); chk(a, "R3 ctrl ack", a, 1); chk(r, "R3 ack release", r, 1);
    wr_byte(8'h35, a, r); chk(a, "R6 addr ack", a, 1);
    wr_byte(8'h5A, a, r); chk(a, "R6 data ack", a, 1);
    chk(pb_a == 10'h235, "R5 R6 pb_addr", int'(pb_a), 'h235);
    chk(pb_d == 8'h5A, "R6 pb_wdata", int'(pb_d), 'h5A);
    exp_mem[10'h235] = 8'h5A;
    bus_stop();
    chk(mem_raddr == 10'h236, "R9 ptr after write", int'(mem_raddr), 'h236);
  endtask

  task automatic t_cur_read();
    bit a, r, st; logic [7:0] b;
    bus_start();
    wr_byte(8'hA5, a, r); chk(a, "R9 read ctrl ack", a, 1);
    rd_byte(1'b0, b, st);
    chk(b == exp_mem[10'h236], "R9 current read", int'(b), int'(exp_mem[10'h236]));
    chk(st, "R8 stable while SCL high", st, 1);
    half();
    chk(!sda_oe, "R11 release after NACK", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic t_page_write();
    bit a, r;
    logic [9:0] ea;
    bus_start();
    wr_byte(8'hA2, a, r);
    wr_byte(8'h1E, a, r);
    for (int k = 0; k < 4; k++) begin
      ea = {2'b01, 4'h1, 4'(4'hE + k)};
      wr_byte(8'hC0 + 8'(k), a, r);
      chk(a && pb_a == ea, "R7 page wrap addr", int'(pb_a), int'(ea));
      exp_mem[ea] = 8'hC0 + 8'(k);
    end
    bus_stop();
  endtask

  task automatic t_random_seq();
    bit a, r, st; logic [7:0] b;
    bus_start();
    wr_byte(8'hA6, a, r);
    wr_byte(8'hFE, a, r); chk(a, "R10 addr ack", a, 1);
    bus_start();
    wr_byte(8'hA7, a, r); chk(a, "R10 read ctrl ack", a, 1);
    rd_byte(1'b1, b, st);
    chk(b == exp_mem[10'h3FE], "R10 random read", int'(b), int'(exp_mem[10'h3FE]));
    rd_byte(1'b1, b, st);
    chk(b == exp_mem[10'h3FF], "R11 sequential next", int'(b), int'(exp_mem[10'h3FF]));
    rd_byte(1'b0, b, st);
    chk(b == exp_mem[0], "R11 wrap to zero", int'(b), int'(exp_mem[0]));
    wr_byte(8'hA0, a, r);
    chk(!a && !sda_oe, "R11 ignored after NACK", a, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hA1, a, r);
    rd_byte(1'b0, b, st);
    chk(b == exp_mem[1], "R9 current after read", int'(b), int'(exp_mem[1]));
    bus_stop();
  endtask

  task automatic t_busy();
    bit a, r; int c0;
    c0 = pb_cnt;
    busy = 1'b1;
    bus_start();
    wr_byte(8'hA0, a, r); chk(!a, "R4 ctrl no ack busy", a, 0);
    wr_byte(8'h10, a, r); chk(!a, "R4 addr no ack busy", a, 0);
    wr_byte(8'h77, a, r); chk(!a, "R4 data no ack busy", a, 0);
    chk(pb_cnt == c0, "R4 no strobe busy", pb_cnt, c0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    wr_byte(8'hA0, a, r); chk(a, "R4 poll ack when idle", a, 1);
    bus_stop();
  endtask

  task automatic t_dontcare();
    bit a, r;
    bus_start();
    wr_byte(8'hAA, a, r);
    wr_byte(8'h40, a, r);
    wr_byte(8'h99, a, r);
    chk(pb_a == 10'h140, "R5 bit3 ignored", int'(pb_a), 'h140);
    exp_mem[10'h140] = 8'h99;
    bus_stop();
  endtask

  task automatic t_abort();
    bit a, r, st; int c0; logic [7:0] b;
    bus_start();
    wr_byte(8'hA0, a, r);
    wr_byte(8'h20, a, r);
    c0 = pb_cnt;
    send_bits(8'hF0, 4);
    bus_stop();
    chk(pb_cnt == c0, "R12 partial byte dropped", pb_cnt, c0);
    scl = 1'b0;
    wr_byte(8'hA0, a, r);
    chk(!a, "R12 bits ignored after STOP", a, 0);
    bus_start();
    wr_byte(8'hA1, a, r);
    rd_byte(1'b0, b, st);
    chk(b == exp_mem[10'h020], "R12 pointer kept", int'(b), int'(exp_mem[10'h020]));
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ram[i]     = pat(i);
      exp_mem[i] = pat(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bad_code();
    t_byte_write();
    t_cur_read();
    t_page_write();
    t_random_seq();
    t_busy();
    t_dontcare();
    t_abort();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule